// File: doc/BRIEF.md
# Soft-Start and Start/Stop Sequencer

This block decides when a switching power converter may run, and how quickly its duty cycle may grow after a start. It watches five stop causes: the internal supply is too low, the bulk input line is low, a remote-off request, a severe overcurrent event and a demagnetization or overvoltage event. It holds a start/stop latch and produces a digital soft-start ramp. The pulse-width modulator uses that ramp as its maximum-duty ceiling.

Any stop cause clears the run latch. While the latch is clear, the ramp discharges one code per clock. The latch is set again only when every cause has cleared and the ramp has fallen below the loop-fault level. After that, the ramp climbs one code every N clocks. The block also compares a loop-feedback code against the loop-fault level. While feedback reads low, the block raises a clamp flag and limits the ceiling to a fixed minimum duty instead of stopping. The bulk-line comparator uses two programmable levels to give hysteresis.

Top module: `soft_start_seq`

## Requirements
- R1: During and straight after reset, `runEn` is 0 and `dutyCeil` is 0. The ramp starts at code 0, and the line-low state starts as asserted.
- R2: When any of `supplyLow`, `remoteOff` (active high), `severeOc` or `demagOv` is 1 before a clock edge, `runEn` is 0 after that edge.
- R3: While `runEn` is 0, the ramp falls by one code per clock down to 0, and `dutyCeil` is 0.
- R4: `runEn` rises at a clock edge only if, before that edge, all stop causes were clear and the ramp was strictly below `faultLevel`.
- R5: While `runEn` is 1, the ramp rises by one code every `stepDiv` clocks and saturates at the all-ones code. A `stepDiv` of 0 or 1 means one step per clock.
- R6: While running with `fbCode >= faultLevel`, `dutyCeil` equals the ramp code.
- R7: `minDutyClamp` is 1 exactly when `fbCode < faultLevel`. While it is 1 and the block is running, `dutyCeil` is the smaller of the ramp and `MIN_DUTY`.
- R8: The line-low state is registered. It is entered when `bulkCode < bulkEnterLow`, and it is left only when `bulkCode > bulkExitLow`. While it is set, it acts as a stop cause.
- R9: A single-cycle `severeOc` pulse stops the output and discharges the ramp. The start sequence then repeats on its own, with no other input change.
- R10: The step divider is cleared while stopped, so the first ramp step comes `stepDiv` clocks after `runEn` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyLow | input | 1 | Internal supply below its undervoltage level |
| remoteOff | input | 1 | Remote-off request, high stops the output |
| severeOc | input | 1 | Severe overcurrent event |
| demagOv | input | 1 | Demagnetization or overvoltage event |
| bulkCode | input | CODE_W | Bulk line sense code |
| bulkEnterLow | input | CODE_W | Level below which line-low is entered |
| bulkExitLow | input | CODE_W | Level above which line-low is left |
| fbCode | input | CODE_W | Loop feedback code |
| faultLevel | input | CODE_W | Loop-fault and restart threshold |
| stepDiv | input | DIV_W | Clocks per ramp step |
| runEn | output | 1 | Converter output enable |
| dutyCeil | output | CODE_W | Maximum-duty ceiling for the modulator |
| minDutyClamp | output | 1 | Feedback is below the loop-fault level |

## Verification
The bench targets these corner cases:
- A release while the ramp is still high. A design that gates restart only on the stop causes would restart at once, at a large duty.
- A bulk level between the two thresholds, both from below and from above. A design without hysteresis would start, or stop, too early.
- A one-cycle overcurrent pulse. A design that treats overcurrent as a latched shutdown would never restart.
- A low-feedback clamp taken while the ramp is above `MIN_DUTY`.
- Step division of 0, 1 and 3, including saturation at the top code. A wrap or an off-by-one in the divider would show up as a wrong ceiling in some cycle.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  // Strobes from the sequencing control to the ramp datapath
  typedef struct packed {
    logic rise;  // latch released: ramp may climb
    logic fall;  // latch stopped: ramp discharges
  } rampCmd_t;
endpackage

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyLow,
  input  logic              remoteOff,
  input  logic              severeOc,
  input  logic              demagOv,
  input  logic [CODE_W-1:0] bulkCode,
  input  logic [CODE_W-1:0] bulkEnterLow,
  input  logic [CODE_W-1:0] bulkExitLow,
  input  logic              rampLow,
  output logic              running,
  output rampCmd_t          cmd
);
  logic lineLow;
  logic lineLowNext;
  logic extStop;
  logic stopReq;

  // Hysteretic line monitor
  always_comb begin
    if (lineLow) lineLowNext = !(bulkCode > bulkExitLow);
    else         lineLowNext = (bulkCode < bulkEnterLow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineLow <= 1'b1;
    else       lineLow <= lineLowNext;
  end

  assign extStop = supplyLow | remoteOff | severeOc | demagOv;
  assign stopReq = extStop | lineLow;

  // Start/stop latch: stop wins, release waits for the ramp floor
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   running <= 1'b0;
    else if (stopReq)            running <= 1'b0;
    else if (!running && rampLow) running <= 1'b1;
  end

  always_comb begin
    cmd.rise = running;
    cmd.fall = !running;
  end

  // R2
  ext_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    extStop |=> !running);

  // R4
  release_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(rampLow));

endmodule

// File: rtl/ssq_dp.sv
module ssq_dp
  import ssq_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int DIV_W    = 16,
  parameter int MIN_DUTY = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  input  logic [DIV_W-1:0]  stepDiv,
  input  logic [CODE_W-1:0] faultLevel,
  input  logic [CODE_W-1:0] fbCode,
  output logic              rampLow,
  output logic [CODE_W-1:0] dutyCeil,
  output logic              minDutyClamp
);
  localparam logic [CODE_W-1:0] RampTop = '1;
  localparam logic [CODE_W-1:0] MinCode = CODE_W'(MIN_DUTY);
  localparam logic [CODE_W-1:0] OneCode = CODE_W'(1);
  localparam logic [DIV_W-1:0]  OneDiv  = DIV_W'(1);

  logic [CODE_W-1:0] ramp;
  logic [DIV_W-1:0]  divCnt;
  logic              stepTick;

  assign stepTick = (stepDiv <= OneDiv) || (divCnt >= stepDiv - OneDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramp   <= '0;
      divCnt <= '0;
    end else if (cmd.rise) begin
      if (stepTick) begin
        divCnt <= '0;
        if (ramp != RampTop) ramp <= ramp + OneCode;
      end else begin
        divCnt <= divCnt + OneDiv;
      end
    end else begin
      divCnt <= '0;
      if (ramp != '0) ramp <= ramp - OneCode;
    end
  end

  assign rampLow      = (ramp < faultLevel);
  assign minDutyClamp = (fbCode < faultLevel);

  always_comb begin
    if (!cmd.rise)                          dutyCeil = '0;
    else if (minDutyClamp && ramp > MinCode) dutyCeil = MinCode;
    else                                    dutyCeil = ramp;
  end

  // R3
  discharge_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fall && ramp != '0) |=> (ramp == $past(ramp) - OneCode));

  // R5
  rise_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rise |=> (ramp == $past(ramp) || ramp == $past(ramp) + OneCode));

  // R7
  clamp_ceil_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minDutyClamp && cmd.rise) |-> (dutyCeil <= MinCode));

endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
  import ssq_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int DIV_W    = 16,
  parameter int MIN_DUTY = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyLow,
  input  logic              remoteOff,
  input  logic              severeOc,
  input  logic              demagOv,
  input  logic [CODE_W-1:0] bulkCode,
  input  logic [CODE_W-1:0] bulkEnterLow,
  input  logic [CODE_W-1:0] bulkExitLow,
  input  logic [CODE_W-1:0] fbCode,
  input  logic [CODE_W-1:0] faultLevel,
  input  logic [DIV_W-1:0]  stepDiv,
  output logic              runEn,
  output logic [CODE_W-1:0] dutyCeil,
  output logic              minDutyClamp
);
  rampCmd_t cmd;
  logic     rampLow;

  ssq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .supplyLow(supplyLow), .remoteOff(remoteOff),
    .severeOc(severeOc), .demagOv(demagOv),
    .bulkCode(bulkCode), .bulkEnterLow(bulkEnterLow), .bulkExitLow(bulkExitLow),
    .rampLow(rampLow), .running(runEn), .cmd(cmd)
  );

  ssq_dp #(.CODE_W(CODE_W), .DIV_W(DIV_W), .MIN_DUTY(MIN_DUTY)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .stepDiv(stepDiv), .faultLevel(faultLevel), .fbCode(fbCode),
    .rampLow(rampLow), .dutyCeil(dutyCeil), .minDutyClamp(minDutyClamp)
  );

  // R1
  stopped_ceil_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> (dutyCeil == '0));

endmodule

// File: tb/soft_start_seq_tb.sv
module soft_start_seq_tb;
  localparam int CODE_W = 8;
  localparam int DIV_W  = 16;
  localparam int MIND   = 20;
  localparam int TOP    = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyLow = 0, remoteOff = 0, severeOc = 0, demagOv = 0;
  logic [CODE_W-1:0] bulkCode = 0, bulkEnterLow = 50, bulkExitLow = 80;
  logic [CODE_W-1:0] fbCode = 0, faultLevel = 10;
  logic [DIV_W-1:0]  stepDiv = 3;
  logic              runEn, minDutyClamp;
  logic [CODE_W-1:0] dutyCeil;

  int nTests = 0, nFail = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  int mRamp = 0, mDiv = 0;
  bit mRun = 0, mLine = 1;

  always #4 clk = ~clk;

  soft_start_seq #(.CODE_W(CODE_W), .DIV_W(DIV_W), .MIN_DUTY(MIND)) u_dut (
    .clk(clk), .rstN(rstN), .supplyLow(supplyLow), .remoteOff(remoteOff),
    .severeOc(severeOc), .demagOv(demagOv), .bulkCode(bulkCode),
    .bulkEnterLow(bulkEnterLow), .bulkExitLow(bulkExitLow), .fbCode(fbCode),
    .faultLevel(faultLevel), .stepDiv(stepDiv), .runEn(runEn),
    .dutyCeil(dutyCeil), .minDutyClamp(minDutyClamp)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int expCeil();
    if (!mRun) return 0;
    if (fbCode < faultLevel && mRamp > MIND) return MIND;
    return mRamp;
  endfunction

  // behavioural model, one update per clock
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRamp = 0; mDiv = 0; mRun = 0; mLine = 1;
    end else begin
      bit stop, nLine, nRun;
      stop  = mLine || supplyLow || remoteOff || severeOc || demagOv;
      nLine = mLine ? (bulkCode <= bulkExitLow) : (bulkCode < bulkEnterLow);
      nRun  = stop ? 0 : (mRun ? 1 : (mRamp < faultLevel));
      if (mRun) begin
        if (stepDiv <= 1 || mDiv >= stepDiv - 1) begin
          mDiv = 0;
          if (mRamp < TOP) mRamp++;
        end else mDiv++;
      end else begin
        mDiv = 0;
        if (mRamp > 0) mRamp--;
      end
      mRun = nRun; mLine = nLine;
      cycles++;
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(tag, "runEn", int'(runEn), int'(mRun));
      check(tag, "dutyCeil", int'(dutyCeil), expCeil());
      check("R7", "minDutyClamp", int'(minDutyClamp), int'(fbCode < faultLevel));
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    waitCyc(3);
    check("R1", "runEn in reset", int'(runEn), 0);
    check("R1", "dutyCeil in reset", int'(dutyCeil), 0);
    rstN = 1'b1;
    waitCyc(2);
    check("R1", "runEn after reset", int'(runEn), 0);

    tag = "R8"; bulkCode = 60;        // between levels, from below
    waitCyc(10);
    check("R8", "no start between levels", int'(runEn), 0);
    bulkCode = 100;
    waitCyc(3);
    check("R8", "start above exit level", int'(runEn), 1);

    tag = "R10"; fbCode = 100;
    waitCyc(40);
    tag = "R6";
    check("R6", "ceiling follows ramp", int'(dutyCeil), mRamp);

    tag = "R7"; fbCode = 5;
    waitCyc(40);
    check("R7", "clamp flag", int'(minDutyClamp), 1);
    check("R7", "clamped ceiling", int'(dutyCeil), MIND);
    check("R7", "still running", int'(runEn), 1);
    fbCode = 100;

    tag = "R2"; remoteOff = 1;
    waitCyc(2);
    check("R2", "remote off stops", int'(runEn), 0);
    waitCyc(8);
    tag = "R4"; remoteOff = 0;
    waitCyc(2);
    check("R4", "hold until ramp floor", int'(runEn), 0);
    tag = "R3";
    waitCyc(40);

    tag = "R9"; severeOc = 1;
    waitCyc(1);
    severeOc = 0;
    check("R9", "overcurrent stops", int'(runEn), 0);
    waitCyc(80);
    check("R9", "hiccup restart", int'(runEn), 1);

    tag = "R2"; supplyLow = 1; waitCyc(5); supplyLow = 0; waitCyc(60);
    demagOv = 1; waitCyc(5); demagOv = 0; waitCyc(60);

    tag = "R8"; bulkCode = 60;        // between levels, from above
    waitCyc(20);
    check("R8", "no stop between levels", int'(runEn), 1);
    bulkCode = 40; waitCyc(30);
    check("R8", "stop below enter level", int'(runEn), 0);
    bulkCode = 70; waitCyc(30);
    check("R8", "stay stopped below exit", int'(runEn), 0);
    bulkCode = 90; waitCyc(40);

    tag = "R5"; stepDiv = 1; waitCyc(30);
    stepDiv = 0; waitCyc(400);
    check("R5", "saturated ceiling", int'(dutyCeil), TOP);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule